// File: doc/BRIEF.md
# Pipelined Linear Track Fitter

This block estimates the parameters of a charged-particle track from the eleven hit coordinates of one candidate. The candidate has five coordinates from strip layers and two each from three pixel layers. Instead of fitting a helix step by step, every output comes from one linear map. Each output row is the dot product of a stored coefficient row with the coordinate vector, plus a stored offset. Eleven rows are computed. The first five are the helix parameters. The remaining six are fit-quality residuals. The sum of the squares of those six residuals is the chi-square. The candidate is accepted when the chi-square does not exceed a limit that is supplied with the candidate.

A sector is one detector module per layer, and each sector has its own set of coefficients and offsets. The coefficients live in a small register memory that is indexed by sector number. Software loads it through a word-wide write port. The memory accepts writes only while no candidate is entering the pipeline and none is in flight. The pipeline takes one candidate on every clock. It returns each result after a fixed five cycles, together with the candidate's tag, so that several of these fitters can be placed side by side.

Top module: `lft_fitter`

## Requirements
- R1: After reset, out_valid and out_accept are low. Every stored coefficient and offset is zero, so a fit made before any write returns all-zero parameters and a chi-square of 0.
- R2: Field i of out_par (bits [i*36 +: 36], i = 0..4) equals the signed sum over j of a(i,j)*x(j), plus b(i). Here x(j) is in_coord[j*16 +: 16] as a signed value, and a and b come from the selected sector. The result is exact for all 16-bit inputs.
- R3: out_chi equals the sum of the squares of rows 5..10, each row formed in the same way as in R2. The result is exact and unsigned, 75 bits wide.
- R4: out_accept is high only with out_valid. When out_valid is high, out_accept equals (out_chi <= the in_chi_limit that was supplied with the same candidate).
- R5: A candidate presented with in_valid at clock edge k appears with out_valid after edge k+4, counting the capture edge as k. Its in_tag appears on out_tag. Back-to-back candidates come out on consecutive cycles in issue order.
- R6: in_sector selects the constant set. A write of cfg_data to (cfg_sector, cfg_row, cfg_col) stores a(row,col) for col 0..10, or the offset b(row) for col 11. Row 0..4 are the parameter rows and row 5..10 are the residual rows.
- R7: A write is ignored while in_valid is high or any candidate is still in the pipeline.
- R8: A write with cfg_row above 10 or cfg_col above 11 is ignored and changes no stored value.
- R9: With all coefficients, offsets and coordinates at full scale (-32768 or 32767), the parameters and the chi-square are returned without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sector | input | 2 | Sector to write |
| cfg_row | input | 4 | Output row to write (0..10) |
| cfg_col | input | 4 | Coefficient column 0..10, or 11 for the offset |
| cfg_data | input | 16 | Signed constant value |
| in_valid | input | 1 | Candidate present |
| in_tag | input | 8 | Candidate tag, returned with the result |
| in_sector | input | 2 | Sector of the candidate |
| in_coord | input | 176 | Eleven signed 16-bit coordinates, coordinate j at [j*16 +: 16] |
| in_chi_limit | input | 75 | Acceptance limit for this candidate |
| out_valid | output | 1 | Result present |
| out_tag | output | 8 | Tag of the result |
| out_par | output | 180 | Five signed 36-bit parameters |
| out_chi | output | 75 | Chi-square |
| out_accept | output | 1 | Chi-square within the limit |

## Verification
The hardest case to reach from the ports is a constant write that arrives while candidates are still moving through the pipeline. This includes the cycles after in_valid has dropped but before the last result has left. Such a write must not land, and the only visible trace of a wrong landing is a changed result on a later fit. The bench streams candidates and raises cfg_we in the same cycle as one of them. It then tries a second write during the drain cycles, and afterwards fires unit-vector candidates whose results expose single stored constants. Unit-vector sweeps over every column and sector, together with limits set at chi, chi-1 and chi+1, cover each coefficient and both sides of the acceptance comparison.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int LFT_W      = 16;
  localparam int LFT_NCOORD = 11;
  localparam int LFT_NPAR   = 5;
  localparam int LFT_NCHI   = 6;
  localparam int LFT_NSECT  = 4;
  localparam int LFT_TAG_W  = 8;

  // bits for a signed sum of nterm products of two w-bit signed values
  function automatic int acc_width(input int w, input int nterm);
    return 2 * w + $clog2(nterm + 1);
  endfunction

  // bits for an unsigned sum of nchi squares of acc_w-bit signed values
  function automatic int chi_width(input int acc_w, input int nchi);
    return 2 * acc_w + $clog2(nchi);
  endfunction
endpackage

// File: rtl/lft_const_mem.sv
module lft_const_mem #(
  parameter int W      = 16,
  parameter int NROW   = 11,
  parameter int NCOL   = 12,
  parameter int NSECT  = 4,
  parameter int SECT_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     busy,
  input  logic [SECT_W-1:0]        wr_sector,
  input  logic [ROW_W-1:0]         wr_row,
  input  logic [COL_W-1:0]         wr_col,
  input  logic [W-1:0]             wr_data,
  input  logic [SECT_W-1:0]        rd_sector,
  output logic [NROW*NCOL*W-1:0]   rd_set
);
  localparam int SET_W = NROW * NCOL * W;
  localparam int MEM_W = NSECT * SET_W;

  logic [MEM_W-1:0] mem_q;
  logic             addr_ok;
  logic             wr_take;
  int               wr_base;

  always_comb begin
    addr_ok = (int'(wr_row) < NROW) && (int'(wr_col) < NCOL) &&
              (int'(wr_sector) < NSECT);
    wr_take = wr_en && !busy && addr_ok;
    wr_base = ((int'(wr_sector) * NROW + int'(wr_row)) * NCOL + int'(wr_col)) * W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_take) begin
      mem_q[wr_base +: W] <= wr_data;
    end
  end

  assign rd_set = mem_q[int'(rd_sector) * SET_W +: SET_W];

  // R7
  cfg_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(mem_q));

  // R8
  cfg_range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> $stable(mem_q));
endmodule

// File: rtl/lft_row_mac.sv
module lft_row_mac #(
  parameter int W      = 16,
  parameter int NCOORD = 11,
  parameter int ACC_W  = 36
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(NCOORD+1)*W-1:0]     coef_row,
  input  logic [NCOORD*W-1:0]         x_vec,
  output logic signed [ACC_W-1:0]     row_sum
);
  localparam int PROD_W = 2 * W;

  function automatic logic signed [PROD_W-1:0] fix_mul(
    input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [PROD_W-1:0] ea;
    logic signed [PROD_W-1:0] eb;
    ea = PROD_W'(a);
    eb = PROD_W'(b);
    return ea * eb;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] p);
    return ACC_W'(p);
  endfunction

  logic signed [PROD_W-1:0] prod_q [NCOORD];
  logic signed [W-1:0]      off_q;
  logic signed [ACC_W-1:0]  acc_c;

  // stage A: one product per coordinate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NCOORD; j++) prod_q[j] <= '0;
      off_q <= '0;
    end else begin
      for (int j = 0; j < NCOORD; j++)
        prod_q[j] <= fix_mul(coef_row[j*W +: W], x_vec[j*W +: W]);
      off_q <= coef_row[NCOORD*W +: W];
    end
  end

  // stage B: adder tree plus offset
  always_comb begin
    acc_c = ACC_W'(off_q);
    for (int j = 0; j < NCOORD; j++) acc_c = acc_c + widen(prod_q[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_sum <= '0;
    else        row_sum <= acc_c;
  end
endmodule

// File: rtl/lft_chi_unit.sv
module lft_chi_unit #(
  parameter int ACC_W = 36,
  parameter int NCHI  = 6,
  parameter int CHI_W = 75
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_in,
  input  logic [NCHI*ACC_W-1:0]    terms,
  input  logic [CHI_W-1:0]         limit_in,
  output logic [CHI_W-1:0]         chi_out,
  output logic                     accept_out
);
  localparam int SQ_W = 2 * ACC_W;

  function automatic logic [SQ_W-1:0] square_term(input logic signed [ACC_W-1:0] t);
    logic signed [SQ_W-1:0] e;
    e = SQ_W'(t);
    return e * e;
  endfunction

  logic [SQ_W-1:0]  sq_q [NCHI];
  logic [CHI_W-1:0] lim_q;
  logic             v_q;
  logic [CHI_W-1:0] chi_c;
  logic [CHI_W-1:0] sq0_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCHI; k++) sq_q[k] <= '0;
      lim_q <= '0;
      v_q   <= 1'b0;
    end else begin
      for (int k = 0; k < NCHI; k++) sq_q[k] <= square_term(terms[k*ACC_W +: ACC_W]);
      lim_q <= limit_in;
      v_q   <= valid_in;
    end
  end

  always_comb begin
    chi_c = '0;
    for (int k = 0; k < NCHI; k++) chi_c = chi_c + CHI_W'(sq_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chi_out    <= '0;
      accept_out <= 1'b0;
    end else begin
      chi_out    <= chi_c;
      accept_out <= v_q && (chi_c <= lim_q);
    end
  end

  assign sq0_wide = CHI_W'(sq_q[0]);

  // R3
  chi_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chi_out >= $past(sq0_wide)));
endmodule

// File: rtl/lft_fitter.sv
module lft_fitter
  import lft_pkg::*;
#(
  parameter int W      = LFT_W,
  parameter int NCOORD = LFT_NCOORD,
  parameter int NPAR   = LFT_NPAR,
  parameter int NCHI   = LFT_NCHI,
  parameter int NSECT  = LFT_NSECT,
  parameter int TAG_W  = LFT_TAG_W,
  localparam int NROW   = NPAR + NCHI,
  localparam int NCOL   = NCOORD + 1,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int ROW_W  = $clog2(NROW),
  localparam int COL_W  = $clog2(NCOL),
  localparam int ACC_W  = acc_width(W, NCOL),
  localparam int CHI_W  = chi_width(ACC_W, NCHI)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SECT_W-1:0]      cfg_sector,
  input  logic [ROW_W-1:0]       cfg_row,
  input  logic [COL_W-1:0]       cfg_col,
  input  logic [W-1:0]           cfg_data,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic [SECT_W-1:0]      in_sector,
  input  logic [NCOORD*W-1:0]    in_coord,
  input  logic [CHI_W-1:0]       in_chi_limit,
  output logic                   out_valid,
  output logic [TAG_W-1:0]       out_tag,
  output logic [NPAR*ACC_W-1:0]  out_par,
  output logic [CHI_W-1:0]       out_chi,
  output logic                   out_accept
);
  localparam int LAT = 5;

  // stage 1 capture
  logic                v1;
  logic [TAG_W-1:0]    tag1;
  logic [SECT_W-1:0]   sect1;
  logic [NCOORD*W-1:0] x1;
  logic [CHI_W-1:0]    lim1;
  // side band for stages 2..5
  logic                v2, v3, v4, v5;
  logic [TAG_W-1:0]    tag2, tag3, tag4, tag5;
  logic [CHI_W-1:0]    lim2, lim3;
  logic signed [ACC_W-1:0] par4 [NPAR];
  logic signed [ACC_W-1:0] par5 [NPAR];

  logic [NROW*NCOL*W-1:0]  const_set;
  logic signed [ACC_W-1:0] row_sum [NROW];
  logic [NCHI*ACC_W-1:0]   chi_terms;
  logic                    pipe_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; tag1 <= '0; sect1 <= '0; x1 <= '0; lim1 <= '0;
    end else begin
      v1    <= in_valid;
      tag1  <= in_tag;
      sect1 <= in_sector;
      x1    <= in_coord;
      lim1  <= in_chi_limit;
    end
  end

  assign pipe_busy = in_valid | v1 | v2 | v3 | v4 | v5;

  lft_const_mem #(
    .W(W), .NROW(NROW), .NCOL(NCOL), .NSECT(NSECT),
    .SECT_W(SECT_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_cmem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .busy(pipe_busy),
    .wr_sector(cfg_sector), .wr_row(cfg_row), .wr_col(cfg_col), .wr_data(cfg_data),
    .rd_sector(sect1), .rd_set(const_set)
  );

  for (genvar r = 0; r < NROW; r++) begin : g_row
    lft_row_mac #(.W(W), .NCOORD(NCOORD), .ACC_W(ACC_W)) u_row (
      .clk(clk), .rst_n(rst_n),
      .coef_row(const_set[r*NCOL*W +: NCOL*W]),
      .x_vec(x1),
      .row_sum(row_sum[r])
    );
  end

  for (genvar k = 0; k < NCHI; k++) begin : g_chi_pack
    assign chi_terms[k*ACC_W +: ACC_W] = row_sum[NPAR+k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0; v5 <= 1'b0;
      tag2 <= '0; tag3 <= '0; tag4 <= '0; tag5 <= '0;
      lim2 <= '0; lim3 <= '0;
      for (int i = 0; i < NPAR; i++) begin
        par4[i] <= '0;
        par5[i] <= '0;
      end
    end else begin
      v2 <= v1; v3 <= v2; v4 <= v3; v5 <= v4;
      tag2 <= tag1; tag3 <= tag2; tag4 <= tag3; tag5 <= tag4;
      lim2 <= lim1; lim3 <= lim2;
      for (int i = 0; i < NPAR; i++) begin
        par4[i] <= row_sum[i];
        par5[i] <= par4[i];
      end
    end
  end

  lft_chi_unit #(.ACC_W(ACC_W), .NCHI(NCHI), .CHI_W(CHI_W)) u_chi (
    .clk(clk), .rst_n(rst_n),
    .valid_in(v3), .terms(chi_terms), .limit_in(lim3),
    .chi_out(out_chi), .accept_out(out_accept)
  );

  for (genvar i = 0; i < NPAR; i++) begin : g_par_out
    assign out_par[i*ACC_W +: ACC_W] = par5[i];
  end

  assign out_valid = v5;
  assign out_tag   = tag5;

  // cycles since reset, saturating at the pipeline depth
  logic [2:0] since_rst;
  logic       lat_ready;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_rst <= '0;
    else if (since_rst != 3'(LAT))  since_rst <= since_rst + 3'd1;
  end
  assign lat_ready = (since_rst == 3'(LAT));

  // R5
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ready |-> (out_valid == $past(in_valid, 5)));

  // R5
  tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_ready && out_valid) |-> (out_tag == $past(in_tag, 5)));

  // R4
  accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> out_valid);
endmodule

// File: tb/lft_fitter_tb.sv
module lft_fitter_tb;
  localparam int W = 16, NC = 11, NP = 5, NX = 6, NR = 11, NS = 4;
  localparam int ACC = 36, CHW = 75, TAGW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sector = '0;
  logic [3:0] cfg_row = '0, cfg_col = '0;
  logic [W-1:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [TAGW-1:0] in_tag = '0;
  logic [1:0] in_sector = '0;
  logic [NC*W-1:0] in_coord = '0;
  logic [CHW-1:0] in_chi_limit = '0;
  logic out_valid, out_accept;
  logic [TAGW-1:0] out_tag;
  logic [NP*ACC-1:0] out_par;
  logic [CHW-1:0] out_chi;

  lft_fitter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sector(cfg_sector),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_tag(in_tag), .in_sector(in_sector),
    .in_coord(in_coord), .in_chi_limit(in_chi_limit),
    .out_valid(out_valid), .out_tag(out_tag), .out_par(out_par),
    .out_chi(out_chi), .out_accept(out_accept)
  );

  always #2 clk = ~clk;

  int cf [NS][NR][NC+1];
  longint ep [256][NP];
  logic [CHW-1:0] ec [256];
  bit ea [256];
  int ecyc [256];
  bit pend [256];
  int n_cmp = 0, n_bad = 0, cyc = 0, issued = 0, next_out = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic shortint hashv(input int a, input int b, input int c);
    int h;
    h = a * 7919 + b * 104729 + c * 15485863 + 97;
    h = h * 1103515245 + 12345;
    h = h ^ (h >>> 13);
    return shortint'(h);
  endfunction

  task automatic cfg_write(input int s, input int r, input int c, input int v, input bit take);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sector = 2'(s); cfg_row = 4'(r); cfg_col = 4'(c); cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (take) cf[s][r][c] = int'(shortint'(v));
  endtask

  // mode: 0 limit=chi, 1 limit=chi-1, 2 limit=chi+1, 3 limit=0
  task automatic issue(input int s, input shortint x[NC], input int mode, input bit with_cfg);
    longint p [NR];
    logic signed [127:0] e;
    logic [127:0] acc;
    logic [CHW-1:0] lim;
    int t;
    @(negedge clk);
    t = issued % 256;
    for (int r = 0; r < NR; r++) begin
      p[r] = longint'(cf[s][r][NC]);
      for (int j = 0; j < NC; j++) p[r] += longint'(cf[s][r][j]) * longint'(x[j]);
    end
    acc = '0;
    for (int k = 0; k < NX; k++) begin
      e = 128'(p[NP+k]);
      acc = acc + 128'(e * e);
    end
    for (int i = 0; i < NP; i++) ep[t][i] = p[i];
    ec[t] = acc[CHW-1:0];
    case (mode)
      0: lim = ec[t];
      1: lim = ec[t] - 1'b1;
      2: lim = ec[t] + 1'b1;
      default: lim = '0;
    endcase
    ea[t] = (ec[t] <= lim);
    pend[t] = 1'b1;
    ecyc[t] = cyc + 1;
    in_valid = 1'b1; in_tag = 8'(t); in_sector = 2'(s); in_chi_limit = lim;
    for (int j = 0; j < NC; j++) in_coord[j*W +: W] = x[j];
    cfg_we = with_cfg;
    if (with_cfg) begin
      cfg_sector = 2'd0; cfg_row = 4'd0; cfg_col = 4'd0; cfg_data = 16'd12345;
    end
    issued++;
  endtask

  task automatic bubble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b0;
    end
  endtask

  // scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int t;
      t = int'(out_tag);
      if (!pend[t]) begin
        chk(1'b0, $sformatf("R5 unexpected result tag %0d expected none", t));
      end else begin
        chk(cyc == ecyc[t] + 4 && t == next_out % 256,
            $sformatf("R5 tag %0d cycle %0d expected tag %0d cycle %0d",
                      t, cyc, next_out % 256, ecyc[t] + 4));
        for (int i = 0; i < NP; i++) begin
          longint act;
          act = longint'($signed(out_par[i*ACC +: ACC]));
          chk(act == ep[t][i], $sformatf("R2 tag %0d par %0d actual %0d expected %0d",
                                         t, i, act, ep[t][i]));
        end
        chk(out_chi == ec[t], $sformatf("R3 tag %0d chi actual %0h expected %0h",
                                        t, out_chi, ec[t]));
        chk(out_accept == ea[t], $sformatf("R4 tag %0d accept actual %0b expected %0b",
                                           t, out_accept, ea[t]));
        pend[t] = 1'b0;
        next_out++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    shortint x [NC];
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0 && out_accept == 1'b0,
        $sformatf("R1 reset outputs actual %0b%0b expected 00", out_valid, out_accept));
    rst_n = 1'b1;
    // R1 empty constants give zero results
    for (int j = 0; j < NC; j++) x[j] = hashv(1, j, 3);
    issue(2, x, 3, 1'b0);
    bubble(8);

    // R6 load every sector
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c <= NC; c++)
          cfg_write(s, r, c, int'(hashv(s, r, c)), 1'b1);
    bubble(2);

    // R2 R3 R4 R6 sweep: unit vectors and hashed patterns per sector, back to back
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < NC; j++) begin
        for (int q = 0; q < NC; q++) x[q] = (q == j) ? shortint'(1) : shortint'(0);
        issue(s, x, j % 4, 1'b0);
        for (int q = 0; q < NC; q++) x[q] = (q == j) ? shortint'(-1) : shortint'(0);
        issue(s, x, (j + 1) % 4, 1'b0);
      end
      for (int k = 0; k < 30; k++) begin
        for (int q = 0; q < NC; q++) x[q] = hashv(k + 50, q, s);
        issue(s, x, k % 4, 1'b0);
        if (k % 7 == 6) bubble(1);
      end
    end
    bubble(8);

    // R9 full-scale constants and coordinates
    for (int r = 0; r < NR; r++)
      for (int c = 0; c <= NC; c++)
        cfg_write(3, r, c, -32768, 1'b1);
    bubble(2);
    for (int q = 0; q < NC; q++) x[q] = shortint'(-32768);
    issue(3, x, 0, 1'b0);
    for (int q = 0; q < NC; q++) x[q] = shortint'(32767);
    issue(3, x, 1, 1'b0);
    for (int q = 0; q < NC; q++) x[q] = (q % 2 == 0) ? shortint'(32767) : shortint'(-32768);
    issue(3, x, 2, 1'b0);
    bubble(8);

    // R7 write alongside a streaming candidate, then during drain
    for (int k = 0; k < 6; k++) begin
      for (int q = 0; q < NC; q++) x[q] = hashv(k, q, 9);
      issue(0, x, k % 4, k == 2);
    end
    bubble(1);
    cfg_write(0, 0, 1, 777, 1'b0);
    bubble(8);
    for (int q = 0; q < NC; q++) x[q] = (q == 0) ? shortint'(1) : shortint'(0);
    issue(0, x, 0, 1'b0);
    for (int q = 0; q < NC; q++) x[q] = (q == 1) ? shortint'(1) : shortint'(0);
    issue(0, x, 0, 1'b0);
    bubble(8);

    // R8 out-of-range row and column
    cfg_write(0, 11, 0, 4321, 1'b0);
    cfg_write(0, 0, 12, 4321, 1'b0);
    cfg_write(1, 15, 15, 4321, 1'b0);
    // R6 a legal write after drain lands
    cfg_write(2, 4, 11, -5, 1'b1);
    bubble(1);
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < NC; j++) begin
        for (int q = 0; q < NC; q++) x[q] = (q == j) ? shortint'(3) : shortint'(0);
        issue(s, x, 2, 1'b0);
      end
    bubble(12);

    // R5 nothing left outstanding
    begin
      int left;
      left = 0;
      for (int t = 0; t < 256; t++) if (pend[t]) left++;
      chk(left == 0, $sformatf("R5 outstanding results actual %0d expected 0", left));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule